// File: doc/BRIEF.md
# Directional Routing Switch Box with Domain Swapping

This block is the switch point where horizontal and vertical routing channels of a programmable fabric meet. Every wire is unidirectional and has exactly one driver. Segments span `SEG` tiles and their ends are staggered, so only one track in each group of `SEG` ends at this box. That track is the only one that may turn here. The remaining tracks are rebuffered straight across, and each moves one position within its group. This rotation keeps identical boxes abuttable.

Each group of `SEG` tracks forms a routing domain. The track that starts a new segment on each side and domain is driven by a configurable multiplexer. The multiplexer can pick one of these sources:
- the ending track from the opposite side;
- the ending tracks from the two sides at right angles;
- the matching tracks of a partner domain, for any turn except the north–west corner;
- the local cluster outputs, since the output connect box is merged into this block.

Multiplexer selects are loaded through a serial configuration chain. After loading, the routing path is purely combinational.

Top module: `dom_switch_box`

## Requirements
- R1: Reset clears the configuration chain, so every multiplexer-driven output is 0. Straight-through outputs keep following their inputs.
- R2: Each clock with `cfg_en_i` high shifts the chain one bit: `cfg_di_i` enters the top bit and `cfg_do_o` shows bit 0. With `cfg_en_i` low the chain holds. After `TOT` shifts, the first bit shifted in sits at bit 0.
- R3: Side codes are 0 north, 1 east, 2 south, 3 west; port bit `side*W + t` is track `t` of that side. Track `t` has domain `k = t/SEG` and position `p = t%SEG`. For `p < SEG-1`, output track `t` on side `s` equals input track `k*SEG+p+1` of side `(s+2)%4`.
- R4: Output position `SEG-1` of side `s`, domain `k`, is driven by multiplexer `m = s*ND+k`. Its select is chain bits `[m*SELW +: SELW]`. Select code 0 drives constant 0.
- R5: Code 1 selects input track `k*SEG` (position 0) of the opposite side `(s+2)%4`.
- R6: Code 2 selects input track `k*SEG` of side `(s+1)%4`. Code 4 selects input track `k*SEG` of side `(s+3)%4`.
- R7: Code 3 selects input track `pk*SEG` of side `(s+1)%4`, and code 5 selects input track `pk*SEG` of side `(s+3)%4`, where `pk = (k^1)%ND`. The swap between north and west is not allowed: the code that would form it (code 5 on north, code 3 on west) drives 0.
- R8: Code `6+j` selects local output `loc_i[j]`. Codes beyond the last local drive 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | configuration clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| cfg_en_i | input | 1 | shift enable for the configuration chain |
| cfg_di_i | input | 1 | serial configuration data in |
| cfg_do_o | output | 1 | serial configuration data out (chain bit 0) |
| chan_i | input | 4*W | tracks arriving from the four sides |
| loc_i | input | NLOC | local cluster outputs |
| chan_o | output | 4*W | tracks leaving toward the four sides |

## Verification
The assertions assume `cfg_en_i` and `cfg_di_i` are at known values on every clock edge after reset. They also assume the routing path is observed only while the chain is not shifting. The stimulus keeps to both assumptions: inputs change only at falling edges, and channel patterns are applied only with shifting disabled. Two kinds of configuration are loaded. In the first, every multiplexer gets the same code. In the second, codes are rotated by multiplexer index, so each multiplexer sees every code. Each configuration is then swept with a walking one over all channel and local inputs and with a few dense patterns.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NSIDE = 4;
  localparam int SEL_ZERO = 0;
  localparam int SEL_STR  = 1;
  localparam int SEL_TA   = 2;
  localparam int SEL_TAX  = 3;
  localparam int SEL_TB   = 4;
  localparam int SEL_TBX  = 5;
  localparam int SEL_LOC0 = 6;

  function automatic int opp(input int s);
    return (s + 2) % NSIDE;
  endfunction

  function automatic int cw(input int s);
    return (s + 1) % NSIDE;
  endfunction

  function automatic int ccw(input int s);
    return (s + 3) % NSIDE;
  endfunction

  // north(0)-west(3) turns stay in their own domain
  function automatic bit swap_ok(input int a, input int b);
    return !((a == 0 && b == 3) || (a == 3 && b == 0));
  endfunction
endpackage

// File: rtl/sb_cfg_chain.sv
module sb_cfg_chain #(
  parameter int TOT = 48
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           di_i,
  output logic [TOT-1:0] q_o,
  output logic           do_o
);
  logic [TOT-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (en_i) q <= {di_i, q[TOT-1:1]};
  end

  assign q_o  = q;
  assign do_o = q[0];

  a_r2_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (q[TOT-1] == $past(di_i)));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q));
endmodule

// File: rtl/sb_route_mux.sv
module sb_route_mux #(
  parameter int NIN  = 7,
  parameter int SELW = 3
) (
  input  logic [SELW-1:0] sel_i,
  input  logic [NIN-1:0]  cand_i,
  output logic            out_o
);
  always_comb begin
    out_o = 1'b0;
    for (int i = 0; i < NIN; i++)
      if (int'(sel_i) == i + 1) out_o = cand_i[i];
  end
endmodule

// File: rtl/dom_switch_box.sv
module dom_switch_box #(
  parameter int W    = 16,
  parameter int SEG  = 4,
  parameter int NLOC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_en_i,
  input  logic            cfg_di_i,
  output logic            cfg_do_o,
  input  logic [4*W-1:0]  chan_i,
  input  logic [NLOC-1:0] loc_i,
  output logic [4*W-1:0]  chan_o
);
  import sb_pkg::*;

  localparam int ND    = W / SEG;
  localparam int NMUX  = NSIDE * ND;
  localparam int NIN   = 5 + NLOC;
  localparam int SELW  = $clog2(NIN + 1);
  localparam int TOT   = NMUX * SELW;

  logic [TOT-1:0] cfg_q;

  sb_cfg_chain #(.TOT(TOT)) u_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cfg_en_i),
    .di_i  (cfg_di_i),
    .q_o   (cfg_q),
    .do_o  (cfg_do_o)
  );

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam int SO = opp(s);
    localparam int SA = cw(s);
    localparam int SB = ccw(s);
    localparam bit XA = swap_ok(s, SA);
    localparam bit XB = swap_ok(s, SB);
    for (genvar k = 0; k < ND; k++) begin : g_dom
      localparam int PK = (k ^ 1) % ND;
      localparam int M  = s * ND + k;
      logic [NIN-1:0]  cand;
      logic [SELW-1:0] sel;
      logic            mux_out;

      // straight-through with position rotation
      for (genvar p = 0; p < SEG - 1; p++) begin : g_pass
        assign chan_o[s*W + k*SEG + p] = chan_i[SO*W + k*SEG + p + 1];
        a_r3_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
          chan_o[s*W + k*SEG + p] == chan_i[SO*W + k*SEG + p + 1]);
      end

      assign cand[SEL_STR-1] = chan_i[SO*W + k*SEG];
      assign cand[SEL_TA-1]  = chan_i[SA*W + k*SEG];
      assign cand[SEL_TB-1]  = chan_i[SB*W + k*SEG];
      if (XA) begin : g_xa
        assign cand[SEL_TAX-1] = chan_i[SA*W + PK*SEG];
      end else begin : g_xa0
        assign cand[SEL_TAX-1] = 1'b0;
      end
      if (XB) begin : g_xb
        assign cand[SEL_TBX-1] = chan_i[SB*W + PK*SEG];
      end else begin : g_xb0
        assign cand[SEL_TBX-1] = 1'b0;
      end
      for (genvar j = 0; j < NLOC; j++) begin : g_loc
        assign cand[SEL_LOC0-1+j] = loc_i[j];
      end

      assign sel = cfg_q[M*SELW +: SELW];

      sb_route_mux #(.NIN(NIN), .SELW(SELW)) u_mux (
        .sel_i (sel),
        .cand_i(cand),
        .out_o (mux_out)
      );

      assign chan_o[s*W + k*SEG + SEG - 1] = mux_out;

      a_r4_zero_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(sel) == SEL_ZERO) |-> !chan_o[s*W + k*SEG + SEG - 1]);
      a_r5_straight: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(sel) == SEL_STR) |-> (chan_o[s*W + k*SEG + SEG - 1] == chan_i[SO*W + k*SEG]));
      if (!XA) begin : g_chk_a
        a_r7_nw_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (int'(sel) == SEL_TAX) |-> !chan_o[s*W + k*SEG + SEG - 1]);
      end
      if (!XB) begin : g_chk_b
        a_r7_nw_blank_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (int'(sel) == SEL_TBX) |-> !chan_o[s*W + k*SEG + SEG - 1]);
      end
    end
  end
endmodule

// File: tb/sim_dom_switch_box.sv
module sim_dom_switch_box;
  localparam int W    = 16;
  localparam int SEG  = 4;
  localparam int NLOC = 2;
  localparam int ND   = W / SEG;
  localparam int NMUX = 4 * ND;
  localparam int SELW = 3;
  localparam int TOT  = NMUX * SELW;
  localparam int NC   = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            cfg_en = 1'b0;
  logic            cfg_di = 1'b0;
  logic            cfg_do;
  logic [4*W-1:0]  chan_in = '0;
  logic [NLOC-1:0] loc_in = '0;
  logic [4*W-1:0]  chan_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dom_switch_box #(.W(W), .SEG(SEG), .NLOC(NLOC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(cfg_en), .cfg_di_i(cfg_di),
    .cfg_do_o(cfg_do), .chan_i(chan_in), .loc_i(loc_in), .chan_o(chan_out)
  );

  function automatic logic [4*W-1:0] model(input logic [4*W-1:0] ci,
                                           input logic [NLOC-1:0] li,
                                           input logic [TOT-1:0] cf);
    logic [4*W-1:0] r;
    r = '0;
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < W; t++) begin
        int p, k, o, a, b, pk, code;
        p = t % SEG; k = t / SEG; o = (s + 2) % 4;
        a = (s + 1) % 4; b = (s + 3) % 4; pk = (k ^ 1) % ND;
        if (p < SEG - 1) r[s*W+t] = ci[o*W + k*SEG + p + 1];
        else begin
          code = int'(cf[(s*ND + k)*SELW +: SELW]);
          case (code)
            0: r[s*W+t] = 1'b0;
            1: r[s*W+t] = ci[o*W + k*SEG];
            2: r[s*W+t] = ci[a*W + k*SEG];
            3: r[s*W+t] = (s == 3) ? 1'b0 : ci[a*W + pk*SEG];
            4: r[s*W+t] = ci[b*W + k*SEG];
            5: r[s*W+t] = (s == 0) ? 1'b0 : ci[b*W + pk*SEG];
            default: r[s*W+t] = (code - 6 < NLOC) ? li[code-6] : 1'b0;
          endcase
        end
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [4*W-1:0] got, input logic [4*W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic load(input logic [TOT-1:0] v);
    for (int i = 0; i < TOT; i++) begin
      @(negedge clk); cfg_en = 1'b1; cfg_di = v[i];
    end
    @(negedge clk); cfg_en = 1'b0; cfg_di = 1'b0;
    checks++;
    if (cfg_do !== v[0]) begin
      errors++;
      $display("FAIL R2 serial out got %b exp %b", cfg_do, v[0]);
    end
  endtask

  task automatic sweep(input string tag, input logic [TOT-1:0] cf);
    for (int j = 0; j < 4*W; j++) begin
      @(negedge clk); chan_in = '0; chan_in[j] = 1'b1; loc_in = '0;
      #1 chk(tag, chan_out, model(chan_in, loc_in, cf));
    end
    for (int j = 0; j < NLOC; j++) begin
      @(negedge clk); chan_in = '0; loc_in = '0; loc_in[j] = 1'b1;
      #1 chk(tag, chan_out, model(chan_in, loc_in, cf));
    end
    @(negedge clk); chan_in = 64'hA5C3_0F96_5A3C_F069; loc_in = 2'b10;
    #1 chk(tag, chan_out, model(chan_in, loc_in, cf));
    @(negedge clk); chan_in = ~64'hA5C3_0F96_5A3C_F069; loc_in = 2'b01;
    #1 chk(tag, chan_out, model(chan_in, loc_in, cf));
    @(negedge clk); chan_in = '1; loc_in = '1;
    #1 chk(tag, chan_out, model(chan_in, loc_in, cf));
  endtask

  function automatic string code_tag(input int c);
    case (c)
      0: return "R4 R3 code0";
      1: return "R5 R3 straight";
      2, 4: return "R6 R3 turn";
      3, 5: return "R7 R3 swap";
      default: return "R8 R3 local";
    endcase
  endfunction

  initial begin
    logic [TOT-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1 reset", '0);
    for (int c = 0; c < NC; c++) begin
      for (int m = 0; m < NMUX; m++) v[m*SELW +: SELW] = SELW'(c);
      load(v);
      sweep(code_tag(c), v);
    end
    for (int c = 0; c < NC; c++) begin
      for (int m = 0; m < NMUX; m++) v[m*SELW +: SELW] = SELW'((m + c) % NC);
      load(v);
      sweep("R4 mux mapping mixed R6 R7 R8", v);
    end
    // R2: chain holds with enable low while data toggles
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); cfg_di = i[0];
    end
    @(negedge clk); chan_in = 64'h1111_2222_4444_8888; loc_in = 2'b11;
    #1 chk("R2 hold", chan_out, model(chan_in, loc_in, v));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule